// File: doc/BRIEF.md
# Two-Byte Receive Buffer with Stalling Byte and Pair Reads

This block sits between the bit-level receiver of a two-wire serial controller and a 32-bit peripheral bus. The receiver offers bytes one at a time through a valid/ready push interface. They are held in a two-entry first-in first-out store. The bus drains them through two read-only windows. The byte window removes one byte per access. The pair window removes both stored bytes in a single access.

A bus master raises a request and keeps it high until the block raises `bus_ready_o`. A read on either window is held off while too few bytes are stored. In the cycle the read data is valid, ready is raised and the store is popped at that clock edge. A 2-bit fill indication always shows the level the store holds after the most recent access. A full store refuses further bytes from the receiver, so no byte is lost or overwritten.

Top module: `rx_pair_fifo`

## Requirements
- R1: A completed byte-window read removes exactly one byte, and bytes are returned in the order in which they were pushed.
- R2: A byte-window read returns the byte in bus bits 7:0, and bits 31:8 are zero.
- R3: A byte-window read issued while the store is empty keeps `bus_ready_o` low until a byte is present, then completes with that byte.
- R4: A completed pair-window read removes two bytes and leaves the store empty.
- R5: A pair-window read returns the older byte in bits 7:0 and the newer byte in bits 15:8, and bits 31:16 are zero.
- R6: A pair-window read issued while fewer than two bytes are stored keeps `bus_ready_o` low until two bytes are present, then completes.
- R7: `rx_level_o` encodes the fill level as 2'b00 for empty, 2'b01 for one byte and 2'b11 for two bytes. It never shows 2'b10, and after each access it reflects the new level.
- R8: A write to either window (`bus_we_i` = 1) is acknowledged at once and changes neither the level nor the stored bytes.
- R9: While two bytes are stored, `push_ready_o` is low, and a byte offered by the receiver waits without being dropped or overwriting stored data.
- R10: A push and a byte-window pop in the same cycle both take effect.
- R11: `bus_ready_o` for a read is raised in the same cycle that `bus_rdata_o` carries the valid data. The window is selected by `bus_sel_i` (0 = byte, 1 = pair).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_valid_i | input | 1 | Receiver offers a byte |
| push_data_i | input | 8 | Byte offered by the receiver |
| push_ready_o | output | 1 | Store accepts the offered byte this cycle |
| bus_req_i | input | 1 | Bus access request, held until ready |
| bus_we_i | input | 1 | Access is a write (ignored by the store) |
| bus_sel_i | input | 1 | Window select: 0 byte, 1 pair |
| bus_wdata_i | input | 32 | Write data (unused) |
| bus_rdata_o | output | 32 | Read data, valid while ready is high |
| bus_ready_o | output | 1 | Access completes at this clock edge |
| rx_level_o | output | 2 | Fill level indication |

## Verification
A push from the receiver and a byte-window pop from the bus can fall in the same clock edge. The bench provokes this by leaving one byte in the store, then launching a push and a byte read in parallel from the same falling edge. Both handshakes are therefore accepted at one rising edge. The result is judged by the returned byte, which must be the old head, by the level, which must stay at one byte, and by a follow-up read, which must return the newly pushed byte. A second overlap occurs when a stalled read is released by the push that lands while it waits. Here the scoreboard checks that the read returns exactly the byte just pushed.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned DEPTH  = 2;

  typedef enum logic [1:0] {
    LVL_EMPTY = 2'b00,
    LVL_ONE   = 2'b01,
    LVL_RSVD  = 2'b10,
    LVL_FULL  = 2'b11
  } lvl_e;

  typedef enum logic {
    WIN_BYTE = 1'b0,
    WIN_PAIR = 1'b1
  } win_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned BYTE_W = rxf_pkg::BYTE_W,
  parameter int unsigned DEPTH  = rxf_pkg::DEPTH,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [BYTE_W-1:0] push_data_i,
  input  logic [CNT_W-1:0]  pop_cnt_i,
  output logic [BYTE_W-1:0] head_o,
  output logic [BYTE_W-1:0] next_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  count_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    for (int unsigned i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < pop_cnt_i) rd_ptr_d = ptr_inc(rd_ptr_d);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      count_q <= count_q + CNT_W'(push_i) - pop_cnt_i;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem_q[g] <= '0;
        else if (push_i && wr_ptr_q == PTR_W'(g)) mem_q[g] <= push_data_i;
      end
    end
  endgenerate

  assign head_o  = mem_q[rd_ptr_q];
  assign next_o  = mem_q[ptr_inc(rd_ptr_q)];
  assign count_o = count_q;
  assign full_o  = (count_q == CNT_W'(DEPTH));

  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_cnt_i <= count_q);
  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  a_r1_single_pop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_cnt_i == CNT_W'(1) && !push_i) |=> count_q == $past(count_q) - 1'b1);
endmodule

// File: rtl/rxf_bus_port.sv
module rxf_bus_port #(
  parameter int unsigned BYTE_W = rxf_pkg::BYTE_W,
  parameter int unsigned BUS_W  = rxf_pkg::BUS_W,
  parameter int unsigned DEPTH  = rxf_pkg::DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  rxf_pkg::win_e     win_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [BYTE_W-1:0] head_i,
  input  logic [BYTE_W-1:0] next_i,
  output logic              ready_o,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [CNT_W-1:0]  pop_cnt_o
);
  import rxf_pkg::*;

  logic rd_req, avail, rd_done;

  assign rd_req  = req_i && !we_i;
  assign avail   = (win_i == WIN_BYTE) ? (count_i != '0) : (count_i == CNT_W'(DEPTH));
  assign rd_done = rd_req && avail;
  // writes complete at once and touch nothing
  assign ready_o = (req_i && we_i) || rd_done;

  always_comb begin
    rdata_o   = '0;
    pop_cnt_o = '0;
    if (rd_done) begin
      if (win_i == WIN_BYTE) begin
        rdata_o   = BUS_W'(head_i);
        pop_cnt_o = CNT_W'(1);
      end else begin
        rdata_o   = BUS_W'({next_i, head_i});
        pop_cnt_o = CNT_W'(DEPTH);
      end
    end
  end

  a_r3_byte_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && win_i == WIN_BYTE && count_i == '0) |-> !ready_o);
  a_r6_pair_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && win_i == WIN_PAIR && count_i != CNT_W'(DEPTH)) |-> !ready_o);
  a_r8_write_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |-> (pop_cnt_o == '0 && ready_o));
  a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && win_i == WIN_BYTE) |-> rdata_o[BUS_W-1:BYTE_W] == '0);
  a_r5_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && win_i == WIN_PAIR) |-> rdata_o[BUS_W-1:2*BYTE_W] == '0);
endmodule

// File: rtl/rxf_level_enc.sv
module rxf_level_enc #(
  parameter int unsigned DEPTH  = rxf_pkg::DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  output rxf_pkg::lvl_e    level_o
);
  import rxf_pkg::*;

  always_comb begin
    if (count_i == '0)                level_o = LVL_EMPTY;
    else if (count_i == CNT_W'(DEPTH)) level_o = LVL_FULL;
    else                              level_o = LVL_ONE;
  end

  a_r7_no_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o != LVL_RSVD);
endmodule

// File: rtl/rx_pair_fifo.sv
module rx_pair_fifo #(
  parameter int unsigned BYTE_W = rxf_pkg::BYTE_W,
  parameter int unsigned BUS_W  = rxf_pkg::BUS_W,
  parameter int unsigned DEPTH  = rxf_pkg::DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_valid_i,
  input  logic [BYTE_W-1:0] push_data_i,
  output logic              push_ready_o,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic              bus_sel_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              bus_ready_o,
  output logic [1:0]        rx_level_o
);
  import rxf_pkg::*;

  logic              full, push;
  logic [CNT_W-1:0]  count, pop_cnt;
  logic [BYTE_W-1:0] head, next;
  lvl_e              level;
  win_e              win;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata_i;
  assign win          = win_e'(bus_sel_i);
  assign push_ready_o = !full;
  assign push         = push_valid_i && push_ready_o;

  rxf_store #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_data_i(push_data_i),
    .pop_cnt_i  (pop_cnt),
    .head_o     (head),
    .next_o     (next),
    .count_o    (count),
    .full_o     (full)
  );

  rxf_bus_port #(.BYTE_W(BYTE_W), .BUS_W(BUS_W), .DEPTH(DEPTH)) i_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (bus_req_i),
    .we_i     (bus_we_i),
    .win_i    (win),
    .count_i  (count),
    .head_i   (head),
    .next_i   (next),
    .ready_o  (bus_ready_o),
    .rdata_o  (bus_rdata_o),
    .pop_cnt_o(pop_cnt)
  );

  rxf_level_enc #(.DEPTH(DEPTH)) i_level (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .count_i(count),
    .level_o(level)
  );

  assign rx_level_o = level;

  a_r4_pair_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_ready_o && !bus_we_i && bus_sel_i) |=> rx_level_o == LVL_EMPTY);
  a_r9_refuse_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_level_o == LVL_FULL) |-> !push_ready_o);
  a_r10_push_pop_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_level_o == LVL_ONE && push && bus_ready_o && !bus_we_i && !bus_sel_i)
    |=> rx_level_o == LVL_ONE);
  a_r8_write_keeps_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && !push_valid_i) |=> $stable(rx_level_o));
endmodule

// File: tb/test_rx_pair_fifo.sv
module test_rx_pair_fifo;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [7:0]  push_data = '0;
  logic        push_ready;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_sel = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [1:0]  rx_level;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pair_fifo i_rx_pair_fifo (
    .clk_i(clk), .rst_ni(rst_n),
    .push_valid_i(push_valid), .push_data_i(push_data), .push_ready_o(push_ready),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_sel_i(bus_sel),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_ready_o(bus_ready),
    .rx_level_o(rx_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] lvl_exp();
    return (exp_q.size() == 0) ? 2'b00 : (exp_q.size() == 1) ? 2'b01 : 2'b11;
  endfunction

  // driver: offer a byte, record it in the scoreboard once accepted
  task automatic push_byte(input logic [7:0] b, output int waits);
    waits = 0;
    @(negedge clk); push_valid = 1'b1; push_data = b;
    forever begin
      #1;
      if (push_ready) break;
      waits++;
      @(negedge clk);
    end
    exp_q.push_back(b);
    @(negedge clk); push_valid = 1'b0;
  endtask

  // bus read plus monitor: compare returned data with scoreboard
  task automatic bus_read(input string req, input logic pair, output int waits);
    logic [31:0] d, exp;
    logic [7:0]  b0, b1;
    waits = 0;
    @(negedge clk); bus_req = 1'b1; bus_we = 1'b0; bus_sel = pair;
    forever begin
      #1;
      if (bus_ready) begin d = bus_rdata; break; end
      waits++;
      @(negedge clk);
    end
    @(negedge clk); bus_req = 1'b0;
    if (pair) begin
      b0 = exp_q.pop_front(); b1 = exp_q.pop_front();
      exp = {16'h0, b1, b0};
    end else begin
      b0 = exp_q.pop_front();
      exp = {24'h0, b0};
    end
    chk(req, d, exp);
  endtask

  task automatic bus_write(input logic pair, input logic [31:0] v);
    @(negedge clk); bus_req = 1'b1; bus_we = 1'b1; bus_sel = pair; bus_wdata = v;
    #1 chk("R8 write ack", {31'h0, bus_ready}, 32'h1);
    @(negedge clk); bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic chk_level(input string req);
    #1 chk(req, {30'h0, rx_level}, {30'h0, lvl_exp()});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int w, wr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R7 reset level", {30'h0, rx_level}, 32'h0);
    chk("R9 reset push_ready", {31'h0, push_ready}, 32'h1);
    chk("R11 idle ready", {31'h0, bus_ready}, 32'h0);

    // R1 R2 order and placement
    push_byte(8'hA5, w); push_byte(8'h3C, w);
    chk_level("R7 two bytes");
    bus_read("R1 R2 first byte", 1'b0, w);
    chk_level("R7 after byte read");
    bus_read("R1 second byte", 1'b0, w);
    chk_level("R7 empty after reads");

    // R9 full refuses, byte waits; R4 R5 pair read
    push_byte(8'h11, w); push_byte(8'h22, w);
    fork
      push_byte(8'h33, wr);
      begin
        repeat (3) @(negedge clk);
        #1 chk("R9 full refuses", {31'h0, push_ready}, 32'h0);
        bus_read("R4 R5 pair data", 1'b1, w);
      end
    join
    chk("R9 push waited", {31'h0, wr > 0}, 32'h1);
    chk_level("R4 level after pair and push");
    bus_read("R9 held byte kept", 1'b0, w);

    // R6 pair read stalls until full
    fork
      bus_read("R6 pair after stall", 1'b1, w);
      begin
        push_byte(8'h44, wr);
        #1 chk("R6 stalled with one byte", {31'h0, bus_ready}, 32'h0);
        push_byte(8'h55, wr);
      end
    join
    chk("R6 waited", {31'h0, w > 0}, 32'h1);
    chk_level("R4 empty after pair");

    // R3 byte read stalls while empty
    fork
      bus_read("R3 byte after stall", 1'b0, w);
      begin repeat (3) @(negedge clk); push_byte(8'h66, wr); end
    join
    chk("R3 waited", {31'h0, w >= 3}, 32'h1);

    // R10 push and pop in one cycle
    push_byte(8'h77, w);
    fork
      bus_read("R10 old head", 1'b0, w);
      push_byte(8'h88, wr);
    join
    chk("R10 push not stalled", wr, 0);
    chk_level("R10 level stays one");
    bus_read("R10 new byte", 1'b0, w);

    // R8 writes ignored
    push_byte(8'h99, w);
    bus_write(1'b0, 32'hDEAD_BEEF);
    bus_write(1'b1, 32'h1234_5678);
    chk_level("R8 level unchanged");
    bus_read("R8 data unchanged", 1'b0, w);
    chk_level("R7 final empty");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule